// File: doc/BRIEF.md
# Bit-Serial-Carry Pipelined 8-bit ALU

This block is an 8-bit arithmetic/logic unit cut into very shallow register stages. One carry bit is resolved per stage. Operand bits wait in skew registers until their carry arrives, and finished result bits are held in de-skew registers until the whole word is ready. This gives a very short path between registers. A new operation can be accepted on every clock. Each result leaves a fixed number of cycles later, together with a carry-out bit.

There is no opcode. The operation comes from independent flags:
- **Operation flags:** three one-hot flags choose AND, XOR or arithmetic (add).
- **Inversion flags:** two flags invert X or Y before the operation.

In arithmetic mode, inverting Y also injects a carry-in of one. The sum then becomes X - Y, and the carry-out is one when no borrow occurs.

Operands enter and results leave over valid/ready streams. Back-pressure is handled as follows:
- If a result is presented and the consumer holds ready low, the whole pipeline freezes. The presented result stays stable and the input side drops ready in the same cycle.
- When the output stage is empty or being drained, the input side is always ready. A pipeline with bubbles therefore keeps accepting work.

Top module: `gpa_alu`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: In arithmetic mode, {out_carry, out_result} equals X' + Y' + inv_y as a 9-bit sum. X' is X inverted when inv_x=1, and Y' is Y inverted when inv_y=1.
- R3: Subtraction (op_arith=1, inv_y=1) gives X - Y modulo 256 with carry 1 when X >= Y. For example, 0xFF-0xFF gives 0x00 with carry 1, and 0xAA-0x99 gives 0x11 with carry 1.
- R4: Addition with no inversion gives 0xFE with carry 1 for 0xFF+0xFF, and 0x43 with carry 1 for 0xAA+0x99.
- R5: inv_x inverts X before the operation in every mode.
- R6: AND mode (op_and=1 only) gives X' & Y', and XOR mode (op_xor=1 only) gives X' ^ Y'. In both, out_carry is 0.
- R7: With none of op_and, op_xor, op_arith set, the result is 0x00 and the carry is 0.
- R8: If several operation flags are set, arithmetic wins over XOR, and XOR wins over AND.
- R9: Without back-pressure, a result leaves on the 9th rising edge after the edge that accepted its operands. One operation is accepted per cycle.
- R10: While out_valid=1 and out_ready=0, in_ready is 0 and out_result and out_carry stay stable. Every stalled cycle delays all operations in flight by one cycle.
- R11: Every accepted operation yields exactly one result, in order. No more than 9 operations are ever in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and flags are presented |
| in_ready | output | 1 | Block accepts the presented operation this cycle |
| x | input | 8 | Operand X |
| y | input | 8 | Operand Y |
| op_and | input | 1 | Select AND mode |
| op_xor | input | 1 | Select XOR mode |
| op_arith | input | 1 | Select arithmetic mode |
| inv_x | input | 1 | Invert X before the operation |
| inv_y | input | 1 | Invert Y before the operation; carry-in of one in arithmetic mode |
| out_valid | output | 1 | Result and carry are presented |
| out_ready | input | 1 | Consumer takes the presented result |
| out_result | output | 8 | Result word |
| out_carry | output | 1 | Carry out of the top bit (0 in logic modes) |

## Verification
The four fixed add and subtract vectors exercise the longest carry ripple (all ones), where a carry lost at any stage would corrupt the high bits. The mixed-bit pairs show that the carry-in injection is correct. Single-mode vectors with and without inv_x tell the AND and XOR paths apart from the arithmetic path and from each other. The empty-flag and all-flags cases pin down the default and the priority. A long random stream, first with ready held high and then with random back-pressure, separates correct latency from results that are merely correct in value. It also checks ordering and the freeze of the presented result during stalls.

// File: rtl/gpa_pkg.sv
package gpa_pkg;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_AND  = 2'd1,
    MODE_XOR  = 2'd2,
    MODE_ADD  = 2'd3
  } alu_mode_e;

  // Priority when several flags are set: add, then xor, then and.
  function automatic alu_mode_e pick_mode(input logic f_and, input logic f_xor,
                                          input logic f_add);
    if (f_add)      return MODE_ADD;
    else if (f_xor) return MODE_XOR;
    else if (f_and) return MODE_AND;
    return MODE_NONE;
  endfunction

  function automatic logic bit_value(input alu_mode_e m, input logic a,
                                     input logic b, input logic c);
    case (m)
      MODE_AND: return a & b;
      MODE_XOR: return a ^ b;
      MODE_ADD: return a ^ b ^ c;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic bit_carry(input alu_mode_e m, input logic a,
                                     input logic b, input logic c);
    if (m == MODE_ADD) return (a & b) | (a & c) | (b & c);
    return 1'b0;
  endfunction

endpackage

// File: rtl/gpa_decode.sv
module gpa_decode #(
  parameter int W = 8
) (
  input  logic [W-1:0]        x,
  input  logic [W-1:0]        y,
  input  logic                op_and,
  input  logic                op_xor,
  input  logic                op_arith,
  input  logic                inv_x,
  input  logic                inv_y,
  output logic [W-1:0]        a_o,
  output logic [W-1:0]        b_o,
  output gpa_pkg::alu_mode_e  mode_o,
  output logic                cin_o
);
  import gpa_pkg::*;

  always_comb begin
    a_o    = inv_x ? ~x : x;
    b_o    = inv_y ? ~y : y;
    mode_o = pick_mode(op_and, op_xor, op_arith);
    cin_o  = inv_y & (mode_o == MODE_ADD);
  end

endmodule

// File: rtl/gpa_carry_slice.sv
module gpa_carry_slice #(
  parameter int W   = 8,
  parameter int BIT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                valid_i,
  input  gpa_pkg::alu_mode_e  mode_i,
  input  logic [W-1:0]        a_i,
  input  logic [W-1:0]        b_i,
  input  logic [W-1:0]        res_i,
  input  logic                c_i,
  output logic                valid_q,
  output gpa_pkg::alu_mode_e  mode_q,
  output logic [W-1:0]        a_q,
  output logic [W-1:0]        b_q,
  output logic [W-1:0]        res_q,
  output logic                c_q
);
  import gpa_pkg::*;

  logic [W-1:0] res_n;
  logic         c_n;

  always_comb begin
    res_n      = res_i;
    res_n[BIT] = bit_value(mode_i, a_i[BIT], b_i[BIT], c_i);
    c_n        = bit_carry(mode_i, a_i[BIT], b_i[BIT], c_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mode_q  <= MODE_NONE;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
      c_q     <= 1'b0;
    end else if (en) begin
      valid_q <= valid_i;
      mode_q  <= mode_i;
      a_q     <= a_i;
      b_q     <= b_i;
      res_q   <= res_n;
      c_q     <= c_n;
    end
  end

endmodule

// File: rtl/gpa_alu.sv
module gpa_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         op_and,
  input  logic         op_xor,
  input  logic         op_arith,
  input  logic         inv_x,
  input  logic         inv_y,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result,
  output logic         out_carry
);
  import gpa_pkg::*;

  localparam int STAGES = W + 1;

  logic [W-1:0] dec_a, dec_b;
  alu_mode_e    dec_mode;
  logic         dec_cin;

  logic         v_s   [0:W];
  alu_mode_e    m_s   [0:W];
  logic [W-1:0] a_s   [0:W];
  logic [W-1:0] b_s   [0:W];
  logic [W-1:0] r_s   [0:W];
  logic         c_s   [0:W];

  logic         adv;
  alu_mode_e    out_mode;

  // The whole pipeline moves only when the output is empty or drained.
  assign adv      = ~v_s[W] | out_ready;
  assign in_ready = adv;

  gpa_decode #(.W(W)) u_dec (
    .x(x), .y(y), .op_and(op_and), .op_xor(op_xor), .op_arith(op_arith),
    .inv_x(inv_x), .inv_y(inv_y),
    .a_o(dec_a), .b_o(dec_b), .mode_o(dec_mode), .cin_o(dec_cin)
  );

  // Entry register: decoded operands and the injected carry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_s[0] <= 1'b0;
      m_s[0] <= MODE_NONE;
      a_s[0] <= '0;
      b_s[0] <= '0;
      r_s[0] <= '0;
      c_s[0] <= 1'b0;
    end else if (adv) begin
      v_s[0] <= in_valid;
      m_s[0] <= dec_mode;
      a_s[0] <= dec_a;
      b_s[0] <= dec_b;
      r_s[0] <= '0;
      c_s[0] <= dec_cin;
    end
  end

  // One carry position resolved per stage.
  for (genvar k = 0; k < W; k++) begin : g_slice
    gpa_carry_slice #(.W(W), .BIT(k)) u_slice (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .valid_i(v_s[k]), .mode_i(m_s[k]), .a_i(a_s[k]), .b_i(b_s[k]),
      .res_i(r_s[k]), .c_i(c_s[k]),
      .valid_q(v_s[k+1]), .mode_q(m_s[k+1]), .a_q(a_s[k+1]), .b_q(b_s[k+1]),
      .res_q(r_s[k+1]), .c_q(c_s[k+1])
    );
  end

  assign out_valid  = v_s[W];
  assign out_result = r_s[W];
  assign out_carry  = c_s[W];
  assign out_mode   = m_s[W];

endmodule

// File: rtl/gpa_alu_chk.sv
module gpa_alu_chk #(
  parameter int W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [W-1:0]       out_result,
  input logic               out_carry,
  input gpa_pkg::alu_mode_e out_mode
);
  import gpa_pkg::*;

  localparam int LAT = W + 1;
  localparam int CW  = $clog2(LAT + 2) + 1;

  logic [CW-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else occ <= occ + CW'(in_valid & in_ready) - CW'(out_valid & out_ready);
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_logic_no_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode != MODE_ADD) |-> !out_carry);

  p_none_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == MODE_NONE) |-> (out_result == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_carry)));

  p_stall_blocks_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_occupancy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(LAT));

  p_out_has_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (occ != '0));

endmodule

bind gpa_alu gpa_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_carry(out_carry), .out_mode(out_mode)
);

// File: tb/gpa_alu_tb.sv
`timescale 1ns/1ps
module gpa_alu_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] x = '0, y = '0;
  logic         op_and = 0, op_xor = 0, op_arith = 0, inv_x = 0, inv_y = 0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic         out_carry;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int stalls = 0;
  bit bp_on = 0;
  bit finished = 0;

  logic [W:0] exp_q [$];
  int         tin_q [$];
  int         sin_q [$];
  string      tag_q [$];

  bit         prev_hold = 0;
  logic [W:0] prev_out;

  always #10 clk = ~clk;

  gpa_alu #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .x(x), .y(y), .op_and(op_and), .op_xor(op_xor), .op_arith(op_arith),
    .inv_x(inv_x), .inv_y(inv_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_carry(out_carry)
  );

  function automatic logic [W:0] model(logic [W-1:0] xv, logic [W-1:0] yv,
                                       logic fa, logic fx, logic fd,
                                       logic ix, logic iy);
    logic [W-1:0] a, b;
    a = ix ? ~xv : xv;
    b = iy ? ~yv : yv;
    if (fd)      return {1'b0, a} + {1'b0, b} + (W+1)'(iy);
    else if (fx) return {1'b0, a ^ b};
    else if (fa) return {1'b0, a & b};
    return '0;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle reference: sample away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (prev_hold)
        check(out_valid && {out_carry, out_result} == prev_out, "R10",
              "held output", {out_valid, out_carry, out_result}, {1'b1, prev_out});
      if (out_valid && !out_ready)
        check(!in_ready, "R10", "in_ready during stall", in_ready, 0);
      if (in_valid && in_ready) begin
        exp_q.push_back(model(x, y, op_and, op_xor, op_arith, inv_x, inv_y));
        tin_q.push_back(cyc);
        sin_q.push_back(stalls);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R11", "result without operation", 1, 0);
        end else begin
          logic [W:0] e;
          int t0, s0;
          string tg;
          e  = exp_q.pop_front();
          t0 = tin_q.pop_front();
          s0 = sin_q.pop_front();
          tg = (tag_q.size() != 0) ? tag_q.pop_front() : "R2";
          check({out_carry, out_result} == e, tg, "carry/result",
                {out_carry, out_result}, e);
          check(cyc - t0 - (stalls - s0) == 9, "R9", "latency",
                cyc - t0 - (stalls - s0), 9);
        end
      end
      if (!in_ready) stalls++;
      prev_hold = out_valid && !out_ready;
      prev_out  = {out_carry, out_result};
    end
  end

  task automatic send(logic [W-1:0] xv, logic [W-1:0] yv, logic fa, logic fx,
                      logic fd, logic ix, logic iy, string tg);
    tag_q.push_back(tg);
    in_valid = 1; x = xv; y = yv;
    op_and = fa; op_xor = fx; op_arith = fd; inv_x = ix; inv_y = iy;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Consumer back-pressure.
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    @(posedge clk); #1;

    // R3 subtraction, R4 addition: long carry ripple and mixed bits
    send(8'hFF, 8'hFF, 0, 0, 1, 0, 1, "R3");
    send(8'hAA, 8'h99, 0, 0, 1, 0, 1, "R3");
    send(8'hFF, 8'hFF, 0, 0, 1, 0, 0, "R4");
    send(8'hAA, 8'h99, 0, 0, 1, 0, 0, "R4");
    send(8'h10, 8'h20, 0, 0, 1, 0, 1, "R3");
    // R6 logic modes, R5 inversion of X
    send(8'hCA, 8'h5F, 1, 0, 0, 0, 0, "R6");
    send(8'hCA, 8'h5F, 0, 1, 0, 0, 0, "R6");
    send(8'hCA, 8'h5F, 1, 0, 0, 1, 0, "R5");
    send(8'hCA, 8'h5F, 0, 1, 0, 1, 1, "R5");
    send(8'h37, 8'h11, 0, 0, 1, 1, 0, "R5");
    // R7 no mode, R8 priority
    send(8'hFF, 8'hFF, 0, 0, 0, 1, 1, "R7");
    send(8'h81, 8'h7F, 1, 1, 1, 0, 0, "R8");
    send(8'h81, 8'h7F, 1, 1, 0, 0, 0, "R8");
    drain();
    check(exp_q.size() == 0, "R11", "directed queue empty", exp_q.size(), 0);

    // R9 back-to-back, no back-pressure
    for (int i = 0; i < 200; i++)
      send($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, "R2");
    drain();

    // R10 random back-pressure
    bp_on = 1;
    for (int i = 0; i < 400; i++)
      send($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, "R2");
    bp_on = 0;
    drain();
    check(exp_q.size() == 0, "R11", "all results returned", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule